// File: doc/BRIEF.md
# Dual-Speed Glitch-Free Clock Switch

This block produces the system clock from one of two free-running sources, a fast one (nominally 4 MHz) and a slow one (nominally 48 kHz). A select bit written by software picks the source. When that bit changes, the block runs a fixed handover. It stops the outgoing clock at its output and lets it run two more edges. It then hands control to the incoming clock, which must run eight edges before the block lets it through. For the whole handover the system clock stays low and a halt output is high, so the processor driven by the system clock stays frozen until the switch is complete.

The block also divides the system clock by four to make a clock-out signal. That divider runs on the system clock, so it stops during a handover and continues from its held count afterwards. A configuration input decides whether the clock-out pin carries this divided clock or serves as an ordinary general-purpose output bit. Each clock domain has its own synchronizer for the select bit. The two domains exchange ownership through toggling tokens, so a select change that arrives during a handover waits until the handover is done and is then evaluated again.

Top module: `dual_clk_switch`

## Requirements
- R1: After reset the fast clock drives `sys_clk`, `halt` is 0 and no handover is pending.
- R2: With the select held steady, `sys_clk` runs at the rate of the selected source (`sel_slow`=1 selects the slow clock, 0 the fast clock).
- R3: While `halt` is 1, `sys_clk` shows no rising edge, and at no time are both sources enabled onto `sys_clk`.
- R4: A handover spans at least two edges of the outgoing clock and at least eight edges of the incoming clock while `halt` is 1. A fast-to-slow handover spans no more than 13 slow edges.
- R5: Every high phase of `sys_clk` lasts at least one half period of the faster source, so no runt pulse appears.
- R6: `clkout` is `sys_clk` divided by four. It advances only on `sys_clk` rising edges, so it holds during a handover and resumes from the count it held.
- R7: With `clkout_en`=1, `pin_out` equals `clkout` and `pin_oe` is 1. With `clkout_en`=0, `pin_out` equals `gpio_dout` and `pin_oe` equals `gpio_oe`.
- R8: A select change made while a handover is running does not cut it short. Once the new source is running, the select is read again, and a second full handover follows if the select asks for it.
- R9: The divider is cleared by reset, so `clkout` first rises on the second `sys_clk` rising edge after reset is released.
- R10: Each domain stays in its drain phase for exactly the drain count and in its wake phase for exactly the wake count of its own clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast free-running source clock |
| clk_slow | input | 1 | Slow free-running source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_slow | input | 1 | Software select: 1 picks the slow source |
| clkout_en | input | 1 | Configuration: 1 routes the divided clock to the pin |
| gpio_dout | input | 1 | General-purpose output value for the pin |
| gpio_oe | input | 1 | General-purpose output enable for the pin |
| sys_clk | output | 1 | Gated system clock |
| halt | output | 1 | High while the system clock is frozen by a handover |
| clkout | output | 1 | System clock divided by four |
| pin_out | output | 1 | Value driven onto the shared pin |
| pin_oe | output | 1 | Output enable of the shared pin |

## Verification
The hardest case to reach is a select change that lands inside a running handover. The bench must let the outgoing domain commit, then reverse the select before the incoming clock is released. The bench waits at fast-clock edges until `halt` rises, then flips the select back one nanosecond later. This forces the block to finish the first handover, run the slow clock for a short moment, and then start a second handover. The bench counts the rising edges of `halt` to confirm that both handovers took place. Monitors that run for the whole test record the shortest high phase of `sys_clk` and the spacing of `clkout` edges. These records show that the divider resumed correctly across every handover.

// File: rtl/dual_clk_switch.sv
module dual_clk_switch #(
  parameter int SYNC_STAGES = 2,
  parameter int DRAIN_EDGES = 2,
  parameter int WAKE_EDGES  = 8,
  parameter int DIV_LOG2    = 2
) (
  input  logic clk_fast,
  input  logic clk_slow,
  input  logic rst_n,
  input  logic sel_slow,
  input  logic clkout_en,
  input  logic gpio_dout,
  input  logic gpio_oe,
  output logic sys_clk,
  output logic halt,
  output logic clkout,
  output logic pin_out,
  output logic pin_oe
);
  localparam int MAXC = (WAKE_EDGES > DRAIN_EDGES) ? WAKE_EDGES : DRAIN_EDGES;
  localparam int CW   = $clog2(MAXC) + 1;

  typedef enum logic [1:0] {ST_OFF, ST_RUN, ST_DRAIN, ST_WAKE} dom_st_t;

  logic [1:0] clk_src, gate, tok, run;
  logic [DIV_LOG2-1:0] dcnt;

  assign clk_src = {clk_slow, clk_fast};

  for (genvar d = 0; d < 2; d++) begin : g_dom
    localparam bit IS_SLOW = (d == 1);
    logic [SYNC_STAGES-1:0] sel_sy, tok_sy;
    logic [CW-1:0] cnt;
    logic tok_q, gate_q, want_me, my_turn;
    dom_st_t st;

    always_ff @(posedge clk_src[d] or negedge rst_n)
      if (!rst_n) begin
        sel_sy <= '0;
        tok_sy <= '0;
      end else begin
        sel_sy <= {sel_sy[SYNC_STAGES-2:0], sel_slow};
        tok_sy <= {tok_sy[SYNC_STAGES-2:0], tok[1-d]};
      end

    assign want_me = (sel_sy[SYNC_STAGES-1] == IS_SLOW);
    assign my_turn = ((tok_sy[SYNC_STAGES-1] ^ tok_q) == IS_SLOW);

    always_ff @(posedge clk_src[d] or negedge rst_n)
      if (!rst_n) begin
        st    <= IS_SLOW ? ST_OFF : ST_RUN;
        cnt   <= '0;
        tok_q <= 1'b0;
      end else begin
        case (st)
          ST_RUN: if (!want_me) begin
            st  <= ST_DRAIN;
            cnt <= '0;
          end
          ST_DRAIN: if (cnt == CW'(DRAIN_EDGES - 1)) begin
            st    <= ST_OFF;
            tok_q <= ~tok_q;
          end else cnt <= cnt + 1'b1;
          ST_OFF: if (my_turn) begin
            st  <= ST_WAKE;
            cnt <= '0;
          end
          default: if (cnt == CW'(WAKE_EDGES - 1)) st <= ST_RUN;
                   else cnt <= cnt + 1'b1;
        endcase
      end

    always_ff @(negedge clk_src[d] or negedge rst_n)
      if (!rst_n) gate_q <= !IS_SLOW;
      else        gate_q <= (st == ST_RUN);

    assign tok[d]  = tok_q;
    assign gate[d] = gate_q;
    assign run[d]  = (st == ST_RUN);

    // R10
    drain_len_chk: assert property (@(posedge clk_src[d]) disable iff (!rst_n)
      (st == ST_OFF && $past(st) == ST_DRAIN) |-> $past(cnt) == CW'(DRAIN_EDGES - 1));
    // R10
    wake_len_chk: assert property (@(posedge clk_src[d]) disable iff (!rst_n)
      (st == ST_RUN && $past(st) == ST_WAKE) |-> $past(cnt) == CW'(WAKE_EDGES - 1));
  end

  assign sys_clk = |(clk_src & gate);
  assign halt    = ~|gate;

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) dcnt <= '0;
    else        dcnt <= dcnt + 1'b1;

  assign clkout  = dcnt[DIV_LOG2-1];
  assign pin_out = clkout_en ? clkout : gpio_dout;
  assign pin_oe  = clkout_en | gpio_oe;

  // R3
  gate_excl_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !(gate[0] && gate[1]));
  // R3
  run_excl_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
    !(run[0] && run[1]));
  // R3
  no_edge_halt_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !halt);
  // R6
  div_step_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    rst_n |=> dcnt == DIV_LOG2'($past(dcnt) + 1'b1));
endmodule

// File: tb/test_dual_clk_switch.sv
`timescale 1ns/1ps
module test_dual_clk_switch;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW_PERIOD = 30;
  localparam int WIN = 600;

  logic clk_fast = 0, clk_slow = 0, rst_n = 0;
  logic sel_slow = 0, clkout_en = 0, gpio_dout = 0, gpio_oe = 0;
  logic sys_clk, halt, clkout, pin_out, pin_oe;

  int checks = 0, errors = 0;
  int n_sys = 0, n_fh = 0, n_sh = 0, n_sys_halt = 0, n_halt_rise = 0;
  int neg_cnt = 0, last_rise = -1, first_delta = -1, div_bad = 0, div_rises = 0;
  bit prev_co = 0;
  realtime t_rise = 0, min_hi = 1e9;

  dual_clk_switch i_dual_clk_switch (
    .clk_fast(clk_fast), .clk_slow(clk_slow), .rst_n(rst_n), .sel_slow(sel_slow),
    .clkout_en(clkout_en), .gpio_dout(gpio_dout), .gpio_oe(gpio_oe),
    .sys_clk(sys_clk), .halt(halt), .clkout(clkout), .pin_out(pin_out), .pin_oe(pin_oe));

  always #(CLK_PERIOD/2) clk_fast = ~clk_fast;
  always #(SLOW_PERIOD/2) clk_slow = ~clk_slow;

  always @(posedge sys_clk) begin
    n_sys++;
    if (halt) n_sys_halt++;
    t_rise = $realtime;
  end
  always @(negedge sys_clk) if (rst_n && t_rise > 0 && ($realtime - t_rise) < min_hi)
    min_hi = $realtime - t_rise;
  always @(negedge sys_clk) if (rst_n) begin
    neg_cnt++;
    if (clkout && !prev_co) begin
      if (last_rise < 0) first_delta = neg_cnt;
      else begin
        div_rises++;
        if (neg_cnt - last_rise != 4) div_bad++;
      end
      last_rise = neg_cnt;
    end
    prev_co = clkout;
  end
  always @(posedge clk_fast) if (rst_n && halt) n_fh++;
  always @(posedge clk_slow) if (rst_n && halt) n_sh++;
  always @(posedge halt) if (rst_n) n_halt_rise++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic freq(input int exp, input string req);
    int s;
    @(posedge clk_fast); #2;
    s = n_sys;
    #(WIN);
    chk((n_sys - s) >= exp - 1 && (n_sys - s) <= exp + 1, req, n_sys - s, exp);
  endtask

  task automatic do_switch(input bit to_slow);
    int f0, s0;
    f0 = n_fh; s0 = n_sh;
    sel_slow = to_slow;
    for (int i = 0; i < 3000 && !halt; i++) @(posedge clk_fast);
    chk(halt, "R4 halt rises", halt, 1);
    for (int i = 0; i < 3000 && halt; i++) @(posedge clk_fast);
    chk(!halt, "R4 halt falls", halt, 0);
    if (to_slow) begin
      chk(n_fh - f0 >= 2, "R4 outgoing fast edges", n_fh - f0, 2);
      chk(n_sh - s0 >= 8 && n_sh - s0 <= 13, "R4 incoming slow edges", n_sh - s0, 11);
    end else begin
      chk(n_sh - s0 >= 2, "R4 outgoing slow edges", n_sh - s0, 2);
      chk(n_fh - f0 >= 8, "R4 incoming fast edges", n_fh - f0, 8);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int h0;
    #52 rst_n = 1;
    #1;
    chk(!halt, "R1 halt after reset", halt, 0);
    for (int k = 0; k < 4; k++) begin
      #7;
      chk(sys_clk == clk_fast, "R1 fast follows", sys_clk, clk_fast);
    end
    freq(WIN / CLK_PERIOD, "R2 fast rate");
    for (int v = 0; v < 4; v++) begin
      gpio_dout = v[0]; gpio_oe = v[1]; #1;
      chk(pin_out == v[0] && pin_oe == v[1], "R7 gpio mode", {pin_oe, pin_out}, v);
    end
    clkout_en = 1;
    for (int k = 0; k < 6; k++) begin
      #13;
      chk(pin_oe && pin_out == clkout, "R7 clkout mode", {pin_oe, pin_out}, {1'b1, clkout});
    end
    do_switch(1);
    freq(WIN / SLOW_PERIOD, "R2 slow rate");
    do_switch(0);
    freq(WIN / CLK_PERIOD, "R2 fast rate after return");
    h0 = n_halt_rise;
    sel_slow = 1;
    for (int i = 0; i < 3000 && !halt; i++) @(posedge clk_fast);
    #1 sel_slow = 0;
    #(SLOW_PERIOD * 60);
    chk(n_halt_rise - h0 == 2, "R8 two handovers", n_halt_rise - h0, 2);
    chk(!halt, "R8 settled", halt, 0);
    freq(WIN / CLK_PERIOD, "R8 fast after holdoff");
    for (int r = 0; r < 3; r++) begin
      do_switch(1);
      do_switch(0);
    end
    chk(n_sys_halt == 0, "R3 no edge while halted", n_sys_halt, 0);
    chk(min_hi >= CLK_PERIOD / 2.0, "R5 min high phase", int'(min_hi), CLK_PERIOD / 2);
    chk(div_bad == 0 && div_rises > 10, "R6 divide by four", div_bad, 0);
    chk(first_delta == 2, "R9 first clkout rise", first_delta, 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule